// File: doc/BRIEF.md
# Shared-Memory Byte Ring Endpoint

This block is the host-side end of a byte ring buffer that lives in another processor's RAM and is shared with software running there. The ring's bookkeeping sits in memory, not in the block. Three header bytes lie directly below the ring's base address. From lowest to highest address they are the size mask (ring length minus one), the producer index and the consumer index. The ring's bytes follow from the base address upward.

The block keeps local copies of the mask and of both indices. For each request it raises a bus request, waits for the grant and runs a short series of single-byte memory cycles through an external cycle engine. It then drops the request and waits for the grant to fall. Each cycle reads the index owned by the peer and writes back the index this block owns.

Clients load a base address and then ask for a status snapshot, take one byte, or give one byte. All four requests use a valid/ready pair. A base of zero turns the endpoint off.

Top module: `shm_ring_endpoint`

## Requirements
- R1: After reset, bus_req, mem_req and all four ready outputs are low, and the endpoint is disabled (base 0).
- R2: A load with a nonzero base reads the byte at base−3 as the mask, base−2 as the producer index and base−1 as the consumer index into local copies, under one bus ownership.
- R3: With base 0 the endpoint is disabled. A load, status, take or give completes with no bus request and no memory write. Status reports empty=1 and full=0, and a take reports no data (hit=0).
- R4: mem_req is high only while bus_req and bus_gnt are both high. Once raised, it holds its address and direction until mem_ack.
- R5: Status reports empty=1 exactly when the producer index read from base−2 equals the local consumer index.
- R6: Status reports full=1 exactly when (local producer index + 1) AND mask equals the consumer index read from base−1.
- R7: A take on a non-empty ring returns the byte at base + local consumer index with hit=1. It then writes (consumer + 1) AND mask to base−1 and keeps that value locally.
- R8: A take on an empty ring returns hit=0 and writes nothing.
- R9: A give writes its byte at base + local producer index. It then writes (producer + 1) AND mask to base−2, and the index wraps at mask+1.
- R10: A give on a full ring is stalled, never dropped. put_ready stays low and nothing is written until the peer frees a slot; then the byte is stored.
- R11: Each completed request holds exactly one bus request/release pair. Its ready pulse occurs only after bus_req has fallen and the grant has been returned.
- R12: When several requests are valid together, the block serves load first, then status, then take, then give, and at most one ready is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Load request |
| init_base | input | AW | Ring base address (0 disables) |
| init_ready | output | 1 | Load complete pulse |
| stat_valid | input | 1 | Status request |
| stat_ready | output | 1 | Status complete pulse |
| stat_empty | output | 1 | Ring empty, valid with stat_ready |
| stat_full | output | 1 | Ring full, valid with stat_ready |
| get_valid | input | 1 | Take request |
| get_ready | output | 1 | Take complete pulse |
| get_hit | output | 1 | A byte was taken, valid with get_ready |
| get_data | output | DW | Byte taken |
| put_valid | input | 1 | Give request |
| put_data | input | DW | Byte to give |
| put_ready | output | 1 | Give accepted pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_req | output | 1 | Memory cycle request, held until mem_ack |
| mem_we | output | 1 | Cycle is a write |
| mem_addr | output | AW | Cycle address |
| mem_wdata | output | DW | Write byte |
| mem_ack | input | 1 | Cycle done; read byte valid |
| mem_rdata | input | DW | Read byte |

## Verification
A wrong local index does not hide for long. The next take reads the wrong slot and returns an unexpected byte, and the next give writes a byte to an unexpected address and an index value the bench did not predict. Each mismatch appears in the single request that follows.

A wrong mask shows as a missing wrap: the index written to the header leaves the range 0..mask. A stale copy of the peer's index shows as an empty or full decision that disagrees with the header bytes the bench placed in memory. All of these appear within one request, because every request rereads the peer's index.

// File: rtl/shm_ring_pkg.sv
package shm_ring_pkg;
  typedef enum logic [1:0] {OP_INIT, OP_STAT, OP_GET, OP_PUT} ring_op_e;
  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_ISSUE, S_WAIT, S_REL} ring_st_e;
  // header byte distances below the base address (decoded by the peer)
  localparam int unsigned OFS_MASK = 3;
  localparam int unsigned OFS_PROD = 2;
  localparam int unsigned OFS_CONS = 1;
endpackage

// File: rtl/shm_ring_idx.sv
module shm_ring_idx #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] loc_prod,
  input  logic [DW-1:0] loc_cons,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] peer,
  output logic [DW-1:0] prod_next,
  output logic [DW-1:0] cons_next,
  output logic          peer_is_cons,
  output logic          peer_is_prod_next
);
  always_comb begin
    prod_next         = (loc_prod + DW'(1)) & mask;
    cons_next         = (loc_cons + DW'(1)) & mask;
    peer_is_cons      = (peer == loc_cons);       // R5/R8 empty test
    peer_is_prod_next = (peer == prod_next);      // R6/R10 full test
  end
endmodule

// File: rtl/shm_ring_mem_port.sv
module shm_ring_mem_port #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (issue) begin
        mem_req   <= 1'b1;
        mem_we    <= issue_we;
        mem_addr  <= issue_addr;
        mem_wdata <= issue_wdata;
      end else if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        done    <= 1'b1;
        rdata   <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/shm_ring_ctrl.sv
module shm_ring_ctrl
  import shm_ring_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_valid,
  input  logic [AW-1:0] init_base,
  output logic          init_ready,
  input  logic          stat_valid,
  output logic          stat_ready,
  output logic          stat_empty,
  output logic          stat_full,
  input  logic          get_valid,
  output logic          get_ready,
  output logic          get_hit,
  output logic [DW-1:0] get_data,
  input  logic          put_valid,
  input  logic [DW-1:0] put_data,
  output logic          put_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          issue,
  output logic          issue_we,
  output logic [AW-1:0] issue_addr,
  output logic [DW-1:0] issue_wdata,
  input  logic          done,
  input  logic [DW-1:0] rdata
);
  ring_st_e      st_q;
  ring_op_e      op_q;
  logic [1:0]    step_q;
  logic [AW-1:0] base_q;
  logic          en_q;
  logic          stall_q;
  logic [DW-1:0] mask_q, prod_q, cons_q, pdata_q;
  logic [DW-1:0] prod_next, cons_next;
  logic          peer_is_cons, peer_is_prod_next;
  logic          any_ready;

  shm_ring_idx #(.DW(DW)) u_idx (
    .loc_prod          (prod_q),
    .loc_cons          (cons_q),
    .mask              (mask_q),
    .peer              (rdata),
    .prod_next         (prod_next),
    .cons_next         (cons_next),
    .peer_is_cons      (peer_is_cons),
    .peer_is_prod_next (peer_is_prod_next)
  );

  assign any_ready = init_ready | stat_ready | get_ready | put_ready;
  assign issue     = (st_q == S_ISSUE);

  // address and direction of the cycle for the current op and step
  always_comb begin
    issue_we    = 1'b0;
    issue_wdata = '0;
    issue_addr  = base_q;
    unique case (op_q)
      OP_INIT: issue_addr = base_q - AW'(OFS_MASK) + AW'(step_q);
      OP_STAT: issue_addr = base_q - AW'(OFS_PROD) + AW'(step_q);
      OP_GET: begin
        case (step_q)
          2'd0:    issue_addr = base_q - AW'(OFS_PROD);
          2'd1:    issue_addr = base_q + AW'(cons_q);
          default: begin
            issue_addr  = base_q - AW'(OFS_CONS);
            issue_we    = 1'b1;
            issue_wdata = cons_next;
          end
        endcase
      end
      OP_PUT: begin
        case (step_q)
          2'd0:    issue_addr = base_q - AW'(OFS_CONS);
          2'd1: begin
            issue_addr  = base_q + AW'(prod_q);
            issue_we    = 1'b1;
            issue_wdata = pdata_q;
          end
          default: begin
            issue_addr  = base_q - AW'(OFS_PROD);
            issue_we    = 1'b1;
            issue_wdata = prod_next;
          end
        endcase
      end
      default: issue_addr = base_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      op_q       <= OP_INIT;
      step_q     <= '0;
      base_q     <= '0;
      en_q       <= 1'b0;
      stall_q    <= 1'b0;
      mask_q     <= '0;
      prod_q     <= '0;
      cons_q     <= '0;
      pdata_q    <= '0;
      bus_req    <= 1'b0;
      init_ready <= 1'b0;
      stat_ready <= 1'b0;
      stat_empty <= 1'b0;
      stat_full  <= 1'b0;
      get_ready  <= 1'b0;
      get_hit    <= 1'b0;
      get_data   <= '0;
      put_ready  <= 1'b0;
    end else begin
      init_ready <= 1'b0;
      stat_ready <= 1'b0;
      get_ready  <= 1'b0;
      put_ready  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          step_q <= '0;
          if (!any_ready) begin
            // R12 fixed order: load, status, take, give
            if (init_valid) begin
              op_q   <= OP_INIT;
              base_q <= init_base;
              en_q   <= 1'b0;
              if (init_base == '0) begin
                mask_q     <= '0;
                prod_q     <= '0;
                cons_q     <= '0;
                init_ready <= 1'b1;          // R3 no bus for base 0
              end else begin
                bus_req <= 1'b1;
                st_q    <= S_ACQ;
              end
            end else if (stat_valid) begin
              op_q <= OP_STAT;
              if (!en_q) begin
                stat_empty <= 1'b1;
                stat_full  <= 1'b0;
                stat_ready <= 1'b1;
              end else begin
                bus_req <= 1'b1;
                st_q    <= S_ACQ;
              end
            end else if (get_valid) begin
              op_q <= OP_GET;
              if (!en_q) begin
                get_hit   <= 1'b0;
                get_ready <= 1'b1;
              end else begin
                bus_req <= 1'b1;
                st_q    <= S_ACQ;
              end
            end else if (put_valid) begin
              op_q    <= OP_PUT;
              pdata_q <= put_data;
              if (!en_q) begin
                put_ready <= 1'b1;
              end else begin
                bus_req <= 1'b1;
                st_q    <= S_ACQ;
              end
            end
          end
        end
        S_ACQ: if (bus_gnt) st_q <= S_ISSUE;
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: begin
          if (done) begin
            // default: advance to the next cycle of this op
            step_q <= step_q + 2'd1;
            st_q   <= S_ISSUE;
            unique case (op_q)
              OP_INIT: begin
                case (step_q)
                  2'd0:    mask_q <= rdata;
                  2'd1:    prod_q <= rdata;
                  default: begin
                    cons_q  <= rdata;
                    en_q    <= 1'b1;
                    bus_req <= 1'b0;
                    st_q    <= S_REL;
                  end
                endcase
              end
              OP_STAT: begin
                if (step_q == 2'd0) begin
                  stat_empty <= peer_is_cons;
                end else begin
                  stat_full <= peer_is_prod_next;
                  bus_req   <= 1'b0;
                  st_q      <= S_REL;
                end
              end
              OP_GET: begin
                case (step_q)
                  2'd0: begin
                    if (peer_is_cons) begin
                      get_hit <= 1'b0;           // R8
                      bus_req <= 1'b0;
                      st_q    <= S_REL;
                    end
                  end
                  2'd1:    get_data <= rdata;
                  default: begin
                    cons_q  <= cons_next;        // R7
                    get_hit <= 1'b1;
                    bus_req <= 1'b0;
                    st_q    <= S_REL;
                  end
                endcase
              end
              OP_PUT: begin
                case (step_q)
                  2'd0: begin
                    if (peer_is_prod_next) begin
                      stall_q <= 1'b1;           // R10 retry later
                      bus_req <= 1'b0;
                      st_q    <= S_REL;
                    end
                  end
                  2'd1:    ;
                  default: begin
                    prod_q  <= prod_next;        // R9
                    bus_req <= 1'b0;
                    st_q    <= S_REL;
                  end
                endcase
              end
              default: ;
            endcase
          end
        end
        S_REL: begin
          if (!bus_gnt) begin                    // R11 grant returned
            st_q    <= S_IDLE;
            stall_q <= 1'b0;
            unique case (op_q)
              OP_INIT: init_ready <= 1'b1;
              OP_STAT: stat_ready <= 1'b1;
              OP_GET:  get_ready  <= 1'b1;
              OP_PUT:  put_ready  <= !stall_q;
              default: ;
            endcase
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shm_ring_endpoint.sv
module shm_ring_endpoint #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_valid,
  input  logic [AW-1:0] init_base,
  output logic          init_ready,
  input  logic          stat_valid,
  output logic          stat_ready,
  output logic          stat_empty,
  output logic          stat_full,
  input  logic          get_valid,
  output logic          get_ready,
  output logic          get_hit,
  output logic [DW-1:0] get_data,
  input  logic          put_valid,
  input  logic [DW-1:0] put_data,
  output logic          put_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic          issue, issue_we, done;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata, rdata;

  shm_ring_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .init_valid  (init_valid),
    .init_base   (init_base),
    .init_ready  (init_ready),
    .stat_valid  (stat_valid),
    .stat_ready  (stat_ready),
    .stat_empty  (stat_empty),
    .stat_full   (stat_full),
    .get_valid   (get_valid),
    .get_ready   (get_ready),
    .get_hit     (get_hit),
    .get_data    (get_data),
    .put_valid   (put_valid),
    .put_data    (put_data),
    .put_ready   (put_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .issue       (issue),
    .issue_we    (issue_we),
    .issue_addr  (issue_addr),
    .issue_wdata (issue_wdata),
    .done        (done),
    .rdata       (rdata)
  );

  shm_ring_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .issue_we    (issue_we),
    .issue_addr  (issue_addr),
    .issue_wdata (issue_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .rdata       (rdata)
  );
endmodule

// File: rtl/shm_ring_endpoint_chk.sv
module shm_ring_endpoint_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          init_ready,
  input logic          stat_ready,
  input logic          get_ready,
  input logic          put_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && !mem_req));

  p_owned_access_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (bus_req && bus_gnt));

  p_hold_access_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_ready_released_r11: assert property (@(posedge clk) disable iff (rst)
    (init_ready || stat_ready || get_ready || put_ready) |-> !bus_req);

  p_one_ready_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_ready, stat_ready, get_ready, put_ready}));
endmodule

bind shm_ring_endpoint shm_ring_endpoint_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .init_ready (init_ready),
  .stat_ready (stat_ready),
  .get_ready  (get_ready),
  .put_ready  (put_ready),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack)
);

// File: tb/shm_ring_endpoint_bench.sv
`timescale 1ns/1ps
module shm_ring_endpoint_bench;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_valid = 1'b0, stat_valid = 1'b0, get_valid = 1'b0, put_valid = 1'b0;
  logic [AW-1:0] init_base = '0;
  logic [DW-1:0] put_data = '0;
  logic init_ready, stat_ready, stat_empty, stat_full, get_ready, get_hit, put_ready;
  logic [DW-1:0] get_data;
  logic bus_req, mem_req, mem_we;
  logic bus_gnt = 1'b0, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  shm_ring_endpoint #(.AW(AW), .DW(DW)) u_shm_ring_endpoint (.*);

  logic [7:0] mem [0:4095];
  int wr_cnt = 0, rise_cnt = 0, checks = 0, errors = 0, cyc = 0;
  logic breq_d = 1'b0;

  logic [AW-1:0] m_base;
  logic [7:0] m_mask, m_prod, m_cons;
  bit m_en;

  function automatic int ma(input logic [AW-1:0] a);
    return int'(a[11:0]);
  endfunction
  function automatic logic [7:0] nxt(input logic [7:0] v, input logic [7:0] m);
    return (v + 8'd1) & m;
  endfunction

  // arbiter and memory models act on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      bus_gnt <= 1'b0;
      mem_ack <= 1'b0;
      breq_d  <= 1'b0;
    end else begin
      breq_d <= bus_req;
      if (bus_req && !breq_d) rise_cnt <= rise_cnt + 1;
      if (bus_req && !bus_gnt && $urandom_range(0, 2) != 0) bus_gnt <= 1'b1;
      else if (!bus_req && bus_gnt && $urandom_range(0, 1) != 0) bus_gnt <= 1'b0;
      if (mem_req && !mem_ack && $urandom_range(0, 2) != 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[ma(mem_addr)];
        if (mem_we) begin
          mem[ma(mem_addr)] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_init(input logic [AW-1:0] b, input logic [7:0] mk,
                         input logic [7:0] pi, input logic [7:0] ci);
    int r0;
    if (b != 0) begin
      mem[ma(b - 3)] = mk; mem[ma(b - 2)] = pi; mem[ma(b - 1)] = ci;
    end
    r0 = rise_cnt;
    @(negedge clk); init_base = b; init_valid = 1'b1;
    do @(negedge clk); while (!init_ready);
    init_valid = 1'b0;
    m_base = b; m_en = (b != 0);
    m_mask = m_en ? mk : 8'd0; m_prod = m_en ? pi : 8'd0; m_cons = m_en ? ci : 8'd0;
    if (m_en) chk(rise_cnt - r0 == 1, "R2", "bus requests for load", rise_cnt - r0, 1);
    else      chk(rise_cnt - r0 == 0, "R3", "bus requests for disabled load", rise_cnt - r0, 0);
  endtask

  task automatic do_stat();
    bit ee, ef;
    ee = m_en ? (mem[ma(m_base - 2)] == m_cons) : 1'b1;
    ef = m_en ? (nxt(m_prod, m_mask) == mem[ma(m_base - 1)]) : 1'b0;
    @(negedge clk); stat_valid = 1'b1;
    do @(negedge clk); while (!stat_ready);
    stat_valid = 1'b0;
    chk(stat_empty == ee, m_en ? "R5" : "R3", "status empty", stat_empty, ee);
    chk(stat_full == ef,  m_en ? "R6" : "R3", "status full", stat_full, ef);
  endtask

  task automatic finish_get(input int w0, input int r0);
    bit eh;
    logic [7:0] ed;
    eh = m_en && (mem[ma(m_base - 2)] != m_cons);
    ed = eh ? mem[ma(m_base + AW'(m_cons))] : 8'h00;
    do @(negedge clk); while (!get_ready);
    get_valid = 1'b0;
    chk(get_hit == eh, eh ? "R7" : (m_en ? "R8" : "R3"), "take hit", get_hit, eh);
    if (eh) begin
      chk(get_data == ed, "R7", "take byte", get_data, ed);
      m_cons = nxt(m_cons, m_mask);
      chk(mem[ma(m_base - 1)] == m_cons, "R7", "consumer header", mem[ma(m_base - 1)], m_cons);
      chk(wr_cnt - w0 == 1, "R7", "writes on take", wr_cnt - w0, 1);
    end else begin
      chk(wr_cnt - w0 == 0, m_en ? "R8" : "R3", "writes on empty take", wr_cnt - w0, 0);
    end
    chk(rise_cnt - r0 == (m_en ? 1 : 0), "R11", "bus requests per take", rise_cnt - r0, m_en ? 1 : 0);
  endtask

  task automatic do_get();
    int w0, r0;
    w0 = wr_cnt; r0 = rise_cnt;
    @(negedge clk); get_valid = 1'b1;
    finish_get(w0, r0);
  endtask

  task automatic do_put(input logic [7:0] d);
    int w0;
    logic [7:0] po, keep;
    w0 = wr_cnt;
    po = mem[ma(m_base - 1)];
    @(negedge clk); put_data = d; put_valid = 1'b1;
    if (m_en && nxt(m_prod, m_mask) == po) begin
      keep = mem[ma(m_base + AW'(m_prod))];
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        if (put_ready) break;
      end
      chk(!put_ready, "R10", "give accepted while full", put_ready, 0);
      chk(wr_cnt == w0, "R10", "writes while full", wr_cnt - w0, 0);
      chk(mem[ma(m_base + AW'(m_prod))] == keep, "R10", "slot while full",
          mem[ma(m_base + AW'(m_prod))], keep);
      mem[ma(m_base - 1)] = nxt(po, m_mask);   // peer frees a slot
      w0 = wr_cnt;
    end
    do @(negedge clk); while (!put_ready);
    put_valid = 1'b0;
    if (m_en) begin
      chk(mem[ma(m_base + AW'(m_prod))] == d, m_mask == 8'd0 ? "R9" : "R9",
          "given byte", mem[ma(m_base + AW'(m_prod))], d);
      m_prod = nxt(m_prod, m_mask);
      chk(mem[ma(m_base - 2)] == m_prod, "R9", "producer header", mem[ma(m_base - 2)], m_prod);
    end else begin
      chk(wr_cnt == w0, "R3", "writes on disabled give", wr_cnt - w0, 0);
    end
  endtask

  initial begin
    int w0, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    chk(!bus_req && !mem_req, "R1", "bus idle after reset", {bus_req, mem_req}, 0);
    chk({init_ready, stat_ready, get_ready, put_ready} == 4'b0, "R1", "ready pulses after reset",
        {init_ready, stat_ready, get_ready, put_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !mem_req, "R1", "bus idle after release of reset", {bus_req, mem_req}, 0);
    m_en = 0; m_base = '0; m_mask = 0; m_prod = 0; m_cons = 0;

    // disabled before any load
    do_stat();
    do_get();
    r0 = rise_cnt;
    do_put(8'h3C);
    chk(rise_cnt == r0, "R3", "bus requests on disabled give", rise_cnt - r0, 0);

    // enabled ring, length 16
    do_init(16'h0100, 8'h0F, 8'h04, 8'h04);
    do_stat();
    do_put(8'hA5);
    do_get();
    do_get();
    // full ring and stalled give
    mem[ma(m_base - 1)] = nxt(m_prod, m_mask);
    do_stat();
    do_put(8'h5A);

    // priority: status beats take
    mem[ma(m_base - 2)] = nxt(m_cons, m_mask);
    w0 = wr_cnt; r0 = rise_cnt;
    @(negedge clk); stat_valid = 1'b1; get_valid = 1'b1;
    do @(negedge clk); while (!stat_ready && !get_ready);
    chk(stat_ready && !get_ready, "R12", "status served first", {stat_ready, get_ready}, 2);
    stat_valid = 1'b0;
    finish_get(w0, r0 + 1);

    // small ring, index wrap
    do_init(16'h0400, 8'h03, 8'h03, 8'h02);
    do_put(8'h11);
    chk(m_prod == 8'h00, "R9", "producer wrapped", m_prod, 0);
    mem[ma(m_base - 2)] = 8'h00; mem[ma(m_base - 1)] = 8'h00;
    do_init(16'h0400, 8'h03, 8'h00, 8'h03);
    mem[ma(m_base - 2)] = 8'h01;
    do_get();
    chk(m_cons == 8'h00, "R7", "consumer wrapped", m_cons, 0);

    // disabled again
    do_init(16'h0000, 8'h00, 8'h00, 8'h00);
    do_put(8'h77);
    do_stat();

    // random mix with peer activity
    do_init(16'h0800, 8'h1F, 8'h00, 8'h00);
    for (int n = 0; n < 300; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) mem[ma(m_base - 2)] = 8'($urandom) & m_mask;
      if (k == 1) mem[ma(m_base - 1)] = 8'($urandom) & m_mask;
      k = $urandom_range(0, 2);
      if (k == 0) do_stat();
      else if (k == 1) do_get();
      else do_put(8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule